// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

This block is a single timer channel. While it is enabled, a counter steps down by one on each selected tick, from a programmable start value to zero. After zero, the next tick restores the start value and counting goes on. Each tick comes from one of two single-cycle tick enables. One is a fixed 1 MHz external tick. The other is derived from the bus clock. A one-bit select picks which of the two is used.

Two match registers set points within the countdown where the channel signals an event, and zero can be a third such point. An interrupt output changes level on every event instead of pulsing. A separate one-cycle strobe marks each event so that a neighbouring status register can latch it. Address decoding and register sequencing sit outside the block. Those neighbours drive the write ports.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, `irqLevel` and `eventPulse` are 0 and the start value and both match registers are 0, so `countOut` reads 0.
- R2: While the channel is disabled, `countOut` shows the start value, and a write to the count port has no effect on the value counting starts from when the channel is enabled later.
- R3: On a 0-to-1 change of `chanEn`, the count is loaded with the start value and `countOut` shows it after the next edge. Each selected tick after that lowers the count by one. A tick at count 0 restores the start value.
- R4: When `extClkSel` is 1, only `extTick` advances the count. When it is 0, only `busTick` advances the count. A pulse on the tick that is not selected leaves the count unchanged.
- R5: A match register whose value is equal to or greater than the start value acts as a match at 0.
- R6: A tick that brings the count onto either effective match value raises an event. The event is a one-cycle `eventPulse` in the same cycle that `countOut` shows the new count. As the count falls, the events come at the larger effective match, then the smaller one, then zero.
- R7: A tick that brings the count onto 0 raises an event only if `ovfIrqEn` is 1 or at least one effective match value is 0. The tick that restores the start value never raises an event.
- R8: Every event inverts `irqLevel`. A tick that raises no event leaves `irqLevel` unchanged, even when the new count satisfies two conditions at once.
- R9: A count-port write while the channel is enabled makes the written value the current count.
- R10: A start-value write while enabled restarts counting from the new value if the old start value was 0 and the new one is not 0. If the old start value was not 0, the write leaves the current count alone, and the new value is used at the next restore.
- R11: While the start value is 0, the channel does not count and raises no events.
- R12: Clearing `chanEn` stops counting and events. The count is restarted from the start value on the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanEn | input | 1 | Channel enable |
| extClkSel | input | 1 | 1 selects the external tick, 0 selects the bus tick |
| ovfIrqEn | input | 1 | Allows an event when the count reaches zero |
| extTick | input | 1 | External 1 MHz tick enable, one cycle per tick |
| busTick | input | 1 | Bus-clock tick enable |
| reloadWrEn | input | 1 | Start-value write strobe |
| reloadWrData | input | CNT_W | Start-value write data |
| matchAWrEn | input | 1 | First match register write strobe |
| matchAWrData | input | CNT_W | First match write data |
| matchBWrEn | input | 1 | Second match register write strobe |
| matchBWrData | input | CNT_W | Second match write data |
| countWrEn | input | 1 | Count write strobe |
| countWrData | input | CNT_W | Count write data |
| countOut | output | CNT_W | Current count while running, otherwise the start value |
| irqLevel | output | 1 | Interrupt level, inverted per event |
| eventPulse | output | 1 | One-cycle strobe per event |

## Verification
The bench uses an 8-bit channel. It sweeps both match registers over every value from 0 to 7 against several start values, with and without the zero event, and it alternates tick sources on every step.

The sweep covers several hazards:
- Matches at or above the start value. A design that compared raw match values would miss these events, or fire on the restore step.
- Two match registers that are equal, or both effectively zero. A design that counted each condition separately would invert the interrupt level twice and hide the event.

Directed runs cover the remaining cases:
- The unselected tick.
- Count writes made while disabled.
- A start value of zero.
- The start-from-zero rewrite of the start value.

A design that used the stale count in any of these cases would show a wrong count.

// File: rtl/dm_timer_pkg.sv
package dm_timer_pkg;
  // Count-register update strobes from control to datapath
  typedef struct packed {
    logic ldWrCount;   // take countWrData
    logic ldNewReload; // take incoming start value (start from zero)
    logic ldReload;    // take stored start value (enable rise)
    logic step;        // decrement or restore
  } cntStrobe_t;
endpackage

// File: rtl/dm_timer_dpath.sv
module dm_timer_dpath
  import dm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic             running,
  input  logic             reloadWrEn,
  input  logic [CNT_W-1:0] reloadWrData,
  input  logic             matchAWrEn,
  input  logic [CNT_W-1:0] matchAWrData,
  input  logic             matchBWrEn,
  input  logic [CNT_W-1:0] matchBWrData,
  input  logic [CNT_W-1:0] countWrData,
  output logic [CNT_W-1:0] countOut,
  output logic             reloadIsZero,
  output logic             nextHitsMatch,
  output logic             nextIsZero
);
  localparam int NUM_MATCH = 2;

  logic [CNT_W-1:0] reloadReg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxtCnt;
  logic [NUM_MATCH-1:0] matchWrEn;
  logic [NUM_MATCH-1:0][CNT_W-1:0] matchWrData;
  logic [NUM_MATCH-1:0] matchHit;

  assign matchWrEn   = {matchBWrEn, matchAWrEn};
  assign matchWrData = {matchBWrData, matchAWrData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reloadReg <= '0;
    else if (reloadWrEn) reloadReg <= reloadWrData;
  end

  assign reloadIsZero = (reloadReg == '0);
  assign nxtCnt       = (cnt == '0) ? reloadReg : cnt - 1'b1;
  assign nextIsZero   = (nxtCnt == '0);

  for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
    logic [CNT_W-1:0] matchReg;
    logic [CNT_W-1:0] effMatch;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) matchReg <= '0;
      else if (matchWrEn[m]) matchReg <= matchWrData[m];
    end
    // a match at or beyond the start value folds onto zero
    assign effMatch    = (matchReg < reloadReg) ? matchReg : '0;
    assign matchHit[m] = (nxtCnt == effMatch);
  end

  assign nextHitsMatch = |matchHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    cnt <= '0;
    else if (strobe.ldWrCount)    cnt <= countWrData;
    else if (strobe.ldNewReload)  cnt <= reloadWrData;
    else if (strobe.ldReload)     cnt <= reloadReg;
    else if (strobe.step)         cnt <= nxtCnt;
  end

  assign countOut = running ? cnt : reloadReg;

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == 4'b0001 && cnt == '0) |=> (cnt == $past(reloadReg)));
  p_no_step_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> !reloadIsZero);
  p_zero_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reloadIsZero && strobe == '0) |=> $stable(cnt));
endmodule

// File: rtl/dm_timer_ctrl.sv
module dm_timer_ctrl
  import dm_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanEn,
  input  logic       extClkSel,
  input  logic       ovfIrqEn,
  input  logic       extTick,
  input  logic       busTick,
  input  logic       countWrEn,
  input  logic       reloadWrEn,
  input  logic       newReloadNz,
  input  logic       reloadIsZero,
  input  logic       nextHitsMatch,
  input  logic       nextIsZero,
  output cntStrobe_t strobe,
  output logic       running,
  output logic       irqLevel,
  output logic       eventPulse
);
  logic enD;
  logic enRise;
  logic tick;
  logic evt;

  assign enRise  = chanEn & ~enD;
  assign tick    = extClkSel ? extTick : busTick;
  assign running = enD;

  always_comb begin
    strobe             = '0;
    strobe.ldWrCount   = chanEn & countWrEn;
    strobe.ldNewReload = chanEn & ~countWrEn & reloadWrEn & reloadIsZero & newReloadNz;
    strobe.ldReload    = enRise & ~strobe.ldWrCount & ~strobe.ldNewReload;
    strobe.step        = chanEn & ~enRise & tick & ~reloadIsZero & ~countWrEn;
  end

  assign evt = strobe.step & (nextHitsMatch | (nextIsZero & ovfIrqEn));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enD        <= 1'b0;
      eventPulse <= 1'b0;
      irqLevel   <= 1'b0;
    end else begin
      enD        <= chanEn;
      eventPulse <= evt;
      irqLevel   <= irqLevel ^ evt;
    end
  end

  p_irq_toggle_r8: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |-> (irqLevel != $past(irqLevel)));
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !eventPulse |-> $stable(irqLevel));
  p_no_evt_disabled_r12: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |-> $past(chanEn));
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic             extClkSel,
  input  logic             ovfIrqEn,
  input  logic             extTick,
  input  logic             busTick,
  input  logic             reloadWrEn,
  input  logic [CNT_W-1:0] reloadWrData,
  input  logic             matchAWrEn,
  input  logic [CNT_W-1:0] matchAWrData,
  input  logic             matchBWrEn,
  input  logic [CNT_W-1:0] matchBWrData,
  input  logic             countWrEn,
  input  logic [CNT_W-1:0] countWrData,
  output logic [CNT_W-1:0] countOut,
  output logic             irqLevel,
  output logic             eventPulse
);
  cntStrobe_t strobe;
  logic running;
  logic reloadIsZero;
  logic nextHitsMatch;
  logic nextIsZero;

  dm_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .extClkSel(extClkSel),
    .ovfIrqEn(ovfIrqEn), .extTick(extTick), .busTick(busTick),
    .countWrEn(countWrEn), .reloadWrEn(reloadWrEn),
    .newReloadNz(|reloadWrData), .reloadIsZero(reloadIsZero),
    .nextHitsMatch(nextHitsMatch), .nextIsZero(nextIsZero),
    .strobe(strobe), .running(running), .irqLevel(irqLevel),
    .eventPulse(eventPulse)
  );

  dm_timer_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .running(running),
    .reloadWrEn(reloadWrEn), .reloadWrData(reloadWrData),
    .matchAWrEn(matchAWrEn), .matchAWrData(matchAWrData),
    .matchBWrEn(matchBWrEn), .matchBWrData(matchBWrData),
    .countWrData(countWrData), .countOut(countOut),
    .reloadIsZero(reloadIsZero), .nextHitsMatch(nextHitsMatch),
    .nextIsZero(nextIsZero)
  );
endmodule

// File: tb/tb_dual_match_timer.sv
module tb_dual_match_timer;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanEn = 0, extClkSel = 0, ovfIrqEn = 0, extTick = 0, busTick = 0;
  logic reloadWrEn = 0, matchAWrEn = 0, matchBWrEn = 0, countWrEn = 0;
  logic [W-1:0] reloadWrData = '0, matchAWrData = '0, matchBWrData = '0, countWrData = '0;
  logic [W-1:0] countOut;
  logic irqLevel, eventPulse;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  // reference state
  int eCnt = 0, eRel = 0, eA = 0, eB = 0;
  bit eOvf = 0, eRun = 0, eLvl = 0, eEvt = 0;

  always #10 clk = ~clk;

  dual_match_timer #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .extClkSel(extClkSel),
    .ovfIrqEn(ovfIrqEn), .extTick(extTick), .busTick(busTick),
    .reloadWrEn(reloadWrEn), .reloadWrData(reloadWrData),
    .matchAWrEn(matchAWrEn), .matchAWrData(matchAWrData),
    .matchBWrEn(matchBWrEn), .matchBWrData(matchBWrData),
    .countWrEn(countWrEn), .countWrData(countWrData),
    .countOut(countOut), .irqLevel(irqLevel), .eventPulse(eventPulse)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic checkAll(input string cntTag);
    check(cntTag, int'(countOut), eRun ? eCnt : eRel);
    check("R6 R7 eventPulse", int'(eventPulse), int'(eEvt));
    check("R8 irqLevel", int'(irqLevel), int'(eLvl));
  endtask

  // one selected tick; reference from the requirements
  task automatic tickStep(input bit useExt, input string cntTag);
    int effA, effB, nxt;
    @(negedge clk);
    extClkSel = useExt; extTick = useExt; busTick = !useExt;
    eEvt = 0;
    if (eRun && eRel != 0) begin
      effA = (eA < eRel) ? eA : 0;   // R5
      effB = (eB < eRel) ? eB : 0;
      nxt  = (eCnt == 0) ? eRel : eCnt - 1;
      if (eCnt != 0)
        eEvt = (nxt == effA) || (nxt == effB) || (nxt == 0 && eOvf);
      eCnt = nxt;
      if (eEvt) eLvl = !eLvl;
    end
    @(negedge clk);
    extTick = 0; busTick = 0;
    checkAll(cntTag);
  endtask

  task automatic setEnable(input bit en);
    @(negedge clk);
    chanEn = en;
    if (en && !eRun) eCnt = eRel;
    eRun = en; eEvt = 0;
    @(negedge clk);
  endtask

  task automatic writeCfg(input int rel, input int a, input int b, input bit ovf);
    @(negedge clk);
    reloadWrEn = 1; reloadWrData = W'(rel);
    matchAWrEn = 1; matchAWrData = W'(a);
    matchBWrEn = 1; matchBWrData = W'(b);
    ovfIrqEn = ovf;
    @(negedge clk);
    reloadWrEn = 0; matchAWrEn = 0; matchBWrEn = 0;
    eRel = rel; eA = a; eB = b; eOvf = ovf;
  endtask

  initial begin : watchdog
    while (cycles < 150000) @(posedge clk) cycles++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    int rels[3] = '{1, 3, 6};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 countOut", int'(countOut), 0);
    check("R1 irqLevel", int'(irqLevel), 0);
    check("R1 eventPulse", int'(eventPulse), 0);
    rstN = 1;
    @(negedge clk);

    // R4 clock select
    writeCfg(5, 0, 0, 0);
    check("R2 disabled shows start value", int'(countOut), 5);
    setEnable(1);
    checkAll("R3 enable load");
    @(negedge clk); extClkSel = 1; busTick = 1;
    @(negedge clk); busTick = 0; checkAll("R4 unselected bus tick");
    tickStep(1, "R4 ext tick");
    @(negedge clk); extClkSel = 0; extTick = 1;
    @(negedge clk); extTick = 0; checkAll("R4 unselected ext tick");
    tickStep(0, "R4 bus tick");

    // R9 count write while enabled
    @(negedge clk); countWrEn = 1; countWrData = 8'd2;
    @(negedge clk); countWrEn = 0; eCnt = 2; eEvt = 0; checkAll("R9 count write");
    tickStep(0, "R9 after write");

    // R2/R12 disable: ticks and count writes have no effect
    setEnable(0);
    checkAll("R12 disabled readback");
    tickStep(0, "R12 disabled tick");
    @(negedge clk); countWrEn = 1; countWrData = 8'd1;
    @(negedge clk); countWrEn = 0; checkAll("R2 write ignored while disabled");
    setEnable(1);
    checkAll("R2 start value after enable");

    // R11 zero start value
    setEnable(0);
    writeCfg(0, 0, 0, 1);
    setEnable(1);
    checkAll("R11 zero start");
    for (int i = 0; i < 3; i++) tickStep(i[0], "R11 no counting");

    // R10 start from zero, then rewrite with nonzero old value
    @(negedge clk); reloadWrEn = 1; reloadWrData = 8'd6;
    @(negedge clk); reloadWrEn = 0; eRel = 6; eCnt = 6; eEvt = 0;
    checkAll("R10 start from new value");
    @(negedge clk); reloadWrEn = 1; reloadWrData = 8'd3;
    @(negedge clk); reloadWrEn = 0; eRel = 3; eA = 0; eB = 0;
    checkAll("R10 current count kept");
    for (int i = 0; i < 8; i++) tickStep(i[0], "R10 restore uses new value");

    // sweep: start values x both matches x zero-event enable
    foreach (rels[r]) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          for (int o = 0; o < 2; o++) begin
            setEnable(0);
            checkAll("R12 disable");
            writeCfg(rels[r], a, b, o[0]);
            setEnable(1);
            checkAll("R3 enable load");
            for (int t = 0; t < rels[r] + 2; t++)
              tickStep(t[0], "R3 R5 count");
          end
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule